// File: doc/BRIEF.md
# TDM Time-Slot Serial Port

This block is a bit-serial transmit and receive port with parallel byte interfaces toward the internal logic. A configuration input selects one of two line modes. In full-time mode the port is an ordinary synchronous serial link. It launches a bit on every transmit clock fall and samples a bit on every receive clock rise. It frames bytes with free-running 8-bit position counters that clear while the matching direction is disabled.

In TDM mode the port joins a shared highway. One bit clock times both directions. A frame sync pulse, sampled on a bit clock rise, marks bit index 0 of the frame. The port owns one 8-bit time slot that starts at a programmable bit index. Only inside that slot does it drive the line, assert the enable for an external line driver, and capture receive bits. At every other bit time the line output is released to high impedance.

All pins are sampled on a fast system clock, and clock edges are found by edge detection. Transmit bytes are written into a one-byte holding register before a slot or byte boundary. If the holding register is empty at that point, the port sends all ones. Each received byte is presented with a one-cycle valid strobe.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, tx_line_oe_o, drv_en_o and rx_valid_o are 0 and tx_line_o is 1.
- R2: In TDM mode, the bit index is set to 0 on a bit clock rise that samples frame_sync_i high. Otherwise each rise advances it modulo FRAME_BITS. Until the first frame sync after reset, no slot exists: the port neither drives the line nor captures data.
- R3: In TDM mode, tx_line_oe_o is 1 for exactly the eight bit times with index cfg_slot_start_i through cfg_slot_start_i+7, including a slot that starts at index 0. It is 0 (line released) for every other bit time.
- R4: In TDM mode, drv_en_o is 1 during the eight slot bit times and 0 outside them.
- R5: In TDM mode, rx_line_i is captured only on bit clock rises whose index lies in the slot. The first captured bit becomes bit 7 of the received byte (MSB first). Line values outside the slot do not affect the byte.
- R6: rx_valid_o is a single-cycle pulse carrying the received byte on rx_byte_o. It follows the rise that captures the eighth bit of a byte.
- R7: Transmit bits leave MSB first. The bit for index k is launched on the bit clock fall just before the rise of index k.
- R8: A byte written with tx_load_i is used once, at the next slot start (TDM) or byte boundary (full-time). When no byte has been written since the last use, the port sends 8'hFF.
- R9: In full-time mode, tx_line_oe_o and drv_en_o equal cfg_tx_en_i, and a bit is launched on every transmit clock fall. A byte is received every eight bit clock rises, and frame_sync_i has no effect.
- R10: In full-time mode with cfg_tx_clk_ext_i=1, bits are launched on falls of tx_clk_i and tx_clk_oe_o is 0. With cfg_tx_clk_ext_i=0, bits are launched on falls of bit_clk_i, tx_clk_o follows bit_clk_i and tx_clk_oe_o is 1.
- R11: With cfg_tx_en_i=0, tx_line_oe_o and drv_en_o stay 0 in both modes. With cfg_rx_en_i=0, no rx_valid_o pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tdm_i | input | 1 | 1 selects TDM slot mode, 0 selects full-time mode |
| cfg_tx_en_i | input | 1 | Transmitter enable |
| cfg_rx_en_i | input | 1 | Receiver enable |
| cfg_tx_clk_ext_i | input | 1 | Full-time mode: 1 takes the transmit clock from tx_clk_i |
| cfg_slot_start_i | input | $clog2(FRAME_BITS) | Bit index of the first slot bit |
| bit_clk_i | input | 1 | Bit clock (shared in TDM, receive clock in full-time) |
| frame_sync_i | input | 1 | Frame start marker, sampled on bit clock rise |
| tx_clk_i | input | 1 | External transmit clock for full-time mode |
| rx_line_i | input | 1 | Serial receive data |
| tx_byte_i | input | 8 | Byte to transmit |
| tx_load_i | input | 1 | Writes tx_byte_i into the holding register |
| tx_line_o | output | 1 | Serial transmit data |
| tx_line_oe_o | output | 1 | Output enable of the transmit line (0 = high impedance) |
| drv_en_o | output | 1 | Enable for an external line driver |
| tx_clk_o | output | 1 | Transmit clock driven out when the port sources it |
| tx_clk_oe_o | output | 1 | Output enable for tx_clk_o |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_byte_o |

## Verification
The bench targets three kinds of mistake. It places the slot at index 0 and at the last eight bits of the frame. A window comparator that mishandles the wrap, or a transmit path that looks at the current index instead of the upcoming one, would then drive the wrong bit or drop the first slot bit. It fills the bit times around the slot with alternating line values, so a receiver that samples outside the window would return a corrupted byte. It also runs a frame before any frame sync, sends a slot with no byte written, and runs full-time mode with frame sync pulses and an external transmit clock. These catch a port that transmits before it is aligned, repeats a stale byte instead of all ones, lets the sync disturb full-time byte framing, or clocks the transmitter from the wrong pin.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int unsigned SLOT_BITS = 8;
    localparam int unsigned POS_W     = $clog2(SLOT_BITS);
    localparam logic [SLOT_BITS-1:0] IDLE_BYTE = '1;

    typedef struct packed {
        logic primed;
        logic prev;
    } edge_state_t;

    typedef struct packed {
        logic [SLOT_BITS-1:0] sh;
        logic [POS_W-1:0]     pos;
        logic [SLOT_BITS-1:0] data;
        logic                 valid;
    } rx_state_t;

    typedef struct packed {
        logic [SLOT_BITS-1:0] hold;
        logic                 full;
        logic [SLOT_BITS-1:0] sh;
        logic [POS_W-1:0]     pos;
        logic                 txd;
        logic                 slot_oe;
    } tx_state_t;

endpackage

// File: rtl/tdm_edge_det.sv
module tdm_edge_det
    import tdm_port_pkg::*;
#(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);

    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.prev   = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = st_q.primed & sig_i & ~st_q.prev;
        end else begin : g_fall
            assign edge_o = st_q.primed & ~sig_i & st_q.prev;
        end
    endgenerate

    // An edge needs the line to hold its new level, so two in a row cannot occur (R5 sampling basis)
    assert_edge_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
    import tdm_port_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rise_i,
    input  logic                          fsync_i,
    input  logic [$clog2(FRAME_BITS)-1:0] start_i,
    output logic                          rx_hit_o,
    output logic [POS_W-1:0]              rx_pos_o,
    output logic                          tx_hit_o,
    output logic [POS_W-1:0]              tx_pos_o
);

    localparam int unsigned SLOT_W = $clog2(FRAME_BITS);
    localparam int unsigned CNT_W  = SLOT_W + 1;
    localparam logic [CNT_W-1:0] PARK = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] rx_idx, tx_idx;

    function automatic logic [CNT_W-1:0] step_idx(input logic [CNT_W-1:0] c);
        if (c == PARK)      return PARK;
        else if (c == LAST) return '0;
        else                return c + CNT_W'(1);
    endfunction

    function automatic logic in_window(input logic [CNT_W-1:0] idx,
                                       input logic [SLOT_W-1:0] st);
        logic [CNT_W:0] ix, lo;
        ix = {1'b0, idx};
        lo = {2'b00, st};
        return (idx != PARK) && (ix >= lo) && (ix < lo + (CNT_W+1)'(SLOT_BITS));
    endfunction

    function automatic logic [POS_W-1:0] win_pos(input logic [CNT_W-1:0] idx,
                                                input logic [SLOT_W-1:0] st);
        logic [CNT_W:0] diff;
        diff = {1'b0, idx} - {2'b00, st};
        return diff[POS_W-1:0];
    endfunction

    always_comb begin
        tx_idx   = step_idx(st_q.cnt);
        rx_idx   = fsync_i ? '0 : tx_idx;
        rx_hit_o = in_window(rx_idx, start_i);
        rx_pos_o = win_pos(rx_idx, start_i);
        tx_hit_o = in_window(tx_idx, start_i);
        tx_pos_o = win_pos(tx_idx, start_i);
        st_d     = st_q;
        if (rise_i) st_d.cnt = rx_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cnt <= PARK;
        else        st_q     <= st_d;
    end

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= PARK);

    assert_fsync_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i && fsync_i |=> st_q.cnt == '0);

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 tdm_i,
    input  logic                 rise_i,
    input  logic                 hit_i,
    input  logic [POS_W-1:0]     slot_pos_i,
    input  logic                 rxd_i,
    output logic [SLOT_BITS-1:0] byte_o,
    output logic                 valid_o
);

    rx_state_t st_d, st_q;
    logic             take;
    logic [POS_W-1:0] bit_pos;
    logic [SLOT_BITS-1:0] shifted;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        take       = tdm_i ? hit_i : 1'b1;
        bit_pos    = tdm_i ? slot_pos_i : st_q.pos;
        shifted    = {st_q.sh[SLOT_BITS-2:0], rxd_i};
        if (!en_i) begin
            st_d.pos = '0;
        end else if (rise_i) begin
            if (!tdm_i) st_d.pos = st_q.pos + POS_W'(1);
            if (take) begin
                st_d.sh = shifted;
                if (bit_pos == POS_W'(SLOT_BITS - 1)) begin
                    st_d.data  = shifted;
                    st_d.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o  = st_q.data;
    assign valid_o = st_q.valid;

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    assert_shift_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sh) |-> $past(rise_i));

    assert_rx_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.valid);

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 tdm_i,
    input  logic                 fall_i,
    input  logic                 hit_i,
    input  logic [POS_W-1:0]     slot_pos_i,
    input  logic                 load_i,
    input  logic [SLOT_BITS-1:0] byte_i,
    output logic                 txd_o,
    output logic                 slot_oe_o
);

    tx_state_t st_d, st_q;
    logic                 drive;
    logic [POS_W-1:0]     bit_pos;
    logic [SLOT_BITS-1:0] src;

    always_comb begin
        st_d    = st_q;
        drive   = tdm_i ? hit_i : 1'b1;
        bit_pos = tdm_i ? slot_pos_i : st_q.pos;
        src     = st_q.full ? st_q.hold : IDLE_BYTE;
        if (load_i) begin
            st_d.hold = byte_i;
            st_d.full = 1'b1;
        end
        if (!en_i) begin
            st_d.pos     = '0;
            st_d.txd     = 1'b1;
            st_d.slot_oe = 1'b0;
        end else if (fall_i) begin
            st_d.slot_oe = tdm_i & hit_i;
            if (!tdm_i) st_d.pos = st_q.pos + POS_W'(1);
            if (!drive) begin
                st_d.txd = 1'b1;
            end else if (bit_pos == '0) begin
                st_d.txd = src[SLOT_BITS-1];
                st_d.sh  = {src[SLOT_BITS-2:0], 1'b1};
                if (!load_i) st_d.full = 1'b0;
            end else begin
                st_d.txd = st_q.sh[SLOT_BITS-1];
                st_d.sh  = {st_q.sh[SLOT_BITS-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o     = st_q.txd;
    assign slot_oe_o = st_q.slot_oe;

    assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) && !$stable(st_q.slot_oe) |-> $past(fall_i));

    assert_line_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) && !$stable(st_q.txd) |-> $past(fall_i));

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tdm_port_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_tdm_i,
    input  logic                          cfg_tx_en_i,
    input  logic                          cfg_rx_en_i,
    input  logic                          cfg_tx_clk_ext_i,
    input  logic [$clog2(FRAME_BITS)-1:0] cfg_slot_start_i,
    input  logic                          bit_clk_i,
    input  logic                          frame_sync_i,
    input  logic                          tx_clk_i,
    input  logic                          rx_line_i,
    input  logic [7:0]                    tx_byte_i,
    input  logic                          tx_load_i,
    output logic                          tx_line_o,
    output logic                          tx_line_oe_o,
    output logic                          drv_en_o,
    output logic                          tx_clk_o,
    output logic                          tx_clk_oe_o,
    output logic [7:0]                    rx_byte_o,
    output logic                          rx_valid_o
);

    logic             tx_clk_sel;
    logic             rx_rise, tx_fall;
    logic             rx_hit, tx_hit;
    logic [POS_W-1:0] rx_pos, tx_pos;
    logic             slot_oe;
    logic             line_oe;

    assign tx_clk_sel = (!cfg_tdm_i && cfg_tx_clk_ext_i) ? tx_clk_i : bit_clk_i;

    tdm_edge_det #(.RISING(1'b1)) u_rx_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (bit_clk_i),
        .edge_o (rx_rise)
    );

    tdm_edge_det #(.RISING(1'b0)) u_tx_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (tx_clk_sel),
        .edge_o (tx_fall)
    );

    tdm_slot_counter #(.FRAME_BITS(FRAME_BITS)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rx_rise),
        .fsync_i  (frame_sync_i),
        .start_i  (cfg_slot_start_i),
        .rx_hit_o (rx_hit),
        .rx_pos_o (rx_pos),
        .tx_hit_o (tx_hit),
        .tx_pos_o (tx_pos)
    );

    tdm_rx_deser u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cfg_rx_en_i),
        .tdm_i      (cfg_tdm_i),
        .rise_i     (rx_rise),
        .hit_i      (rx_hit),
        .slot_pos_i (rx_pos),
        .rxd_i      (rx_line_i),
        .byte_o     (rx_byte_o),
        .valid_o    (rx_valid_o)
    );

    tdm_tx_ser u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cfg_tx_en_i),
        .tdm_i      (cfg_tdm_i),
        .fall_i     (tx_fall),
        .hit_i      (tx_hit),
        .slot_pos_i (tx_pos),
        .load_i     (tx_load_i),
        .byte_i     (tx_byte_i),
        .txd_o      (tx_line_o),
        .slot_oe_o  (slot_oe)
    );

    assign line_oe      = cfg_tdm_i ? slot_oe : cfg_tx_en_i;
    assign tx_line_oe_o = line_oe;
    assign drv_en_o     = line_oe;
    assign tx_clk_o     = bit_clk_i;
    assign tx_clk_oe_o  = !cfg_tdm_i && !cfg_tx_clk_ext_i;

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_en_i && $past(!cfg_tx_en_i) |-> !tx_line_oe_o && !drv_en_o);

endmodule

// File: tb/tdm_slot_port_tb.sv
module tdm_slot_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 32;
    localparam int SW         = $clog2(FRAME);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_tdm = 1'b0;
    logic          cfg_tx_en = 1'b0;
    logic          cfg_rx_en = 1'b0;
    logic          cfg_ext = 1'b0;
    logic [SW-1:0] cfg_start = '0;
    logic          bit_clk = 1'b1;
    logic          fsync = 1'b0;
    logic          tx_clk_in = 1'b1;
    logic          rx_line = 1'b1;
    logic [7:0]    tx_byte = '0;
    logic          tx_load = 1'b0;
    logic          tx_line, tx_line_oe, drv_en, tx_clk_out, tx_clk_oe;
    logic [7:0]    rx_byte;
    logic          rx_valid;

    int   checks = 0;
    int   errors = 0;
    int   vcount = 0;
    logic [7:0] vbyte = '0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_port #(.FRAME_BITS(FRAME)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_tdm_i        (cfg_tdm),
        .cfg_tx_en_i      (cfg_tx_en),
        .cfg_rx_en_i      (cfg_rx_en),
        .cfg_tx_clk_ext_i (cfg_ext),
        .cfg_slot_start_i (cfg_start),
        .bit_clk_i        (bit_clk),
        .frame_sync_i     (fsync),
        .tx_clk_i         (tx_clk_in),
        .rx_line_i        (rx_line),
        .tx_byte_i        (tx_byte),
        .tx_load_i        (tx_load),
        .tx_line_o        (tx_line),
        .tx_line_oe_o     (tx_line_oe),
        .drv_en_o         (drv_en),
        .tx_clk_o         (tx_clk_out),
        .tx_clk_oe_o      (tx_clk_oe),
        .rx_byte_o        (rx_byte),
        .rx_valid_o       (rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount = vcount + 1;
            vbyte  = rx_byte;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_byte(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // One bit period: fall, low half, rise, high half. Samples outputs late in the low half.
    task automatic bit_cycle(input logic fs, input logic rb,
                             output logic s_oe, output logic s_txd,
                             output logic s_en, output logic s_ck);
        @(negedge clk);
        bit_clk = 1'b0;
        fsync   = fs;
        rx_line = rb;
        repeat (3) @(negedge clk);
        s_oe  = tx_line_oe;
        s_txd = tx_line;
        s_en  = drv_en;
        s_ck  = tx_clk_out;
        @(negedge clk);
        bit_clk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic tdm_frame(input bit use_fs, input int start, input logic [7:0] rx_slot,
                             input bit exp_drive, input logic [7:0] exp_tx,
                             input int exp_valid, input string req);
        int v0;
        logic s_oe, s_txd, s_en, s_ck;
        v0 = vcount;
        for (int k = 0; k < FRAME; k++) begin
            bit in_slot;
            logic rb;
            in_slot = (k >= start) && (k < start + 8);
            rb = in_slot ? rx_slot[7-(k-start)] : logic'(k % 2);
            bit_cycle(use_fs && (k == 0), rb, s_oe, s_txd, s_en, s_ck);
            check(req, $sformatf("line oe bit %0d", k), 32'(s_oe), 32'(exp_drive && in_slot));
            check(req, $sformatf("driver enable bit %0d", k), 32'(s_en), 32'(exp_drive && in_slot));
            if (exp_drive && in_slot)
                check(req, $sformatf("tx bit %0d", k), 32'(s_txd), 32'(exp_tx[7-(k-start)]));
        end
        check(req, "rx valid pulses", 32'(vcount - v0), 32'(exp_valid));
        if (exp_valid > 0) check(req, "rx byte", 32'(vbyte), 32'(rx_slot));
    endtask

    task automatic test_reset();
        check("R1", "line oe", 32'(tx_line_oe), 32'd0);
        check("R1", "driver enable", 32'(drv_en), 32'd0);
        check("R1", "rx valid", 32'(rx_valid), 32'd0);
        check("R1", "tx line", 32'(tx_line), 32'd1);
    endtask

    task automatic test_presync();
        cfg_tdm = 1'b1; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1; cfg_start = SW'(5);
        tdm_frame(1'b0, 5, 8'hA5, 1'b0, 8'h00, 0, "R2");
    endtask

    task automatic test_slot_basic();
        load_byte(8'hC3);
        tdm_frame(1'b1, 5, 8'hA5, 1'b1, 8'hC3, 1, "R3 R4 R5 R6 R7");
    endtask

    task automatic test_idle_ones();
        tdm_frame(1'b1, 5, 8'h5A, 1'b1, 8'hFF, 1, "R8");
    endtask

    task automatic test_boundaries();
        cfg_start = SW'(0);
        load_byte(8'h96);
        tdm_frame(1'b1, 0, 8'h3C, 1'b1, 8'h96, 1, "R3 start 0");
        cfg_start = SW'(FRAME - 8);
        load_byte(8'h71);
        tdm_frame(1'b1, FRAME - 8, 8'hE8, 1'b1, 8'h71, 1, "R3 last slot");
    endtask

    task automatic test_enables_off();
        cfg_start = SW'(5);
        cfg_tx_en = 1'b0;
        tdm_frame(1'b1, 5, 8'h4B, 1'b0, 8'h00, 1, "R11 tx off");
        cfg_rx_en = 1'b0;
        tdm_frame(1'b1, 5, 8'hD2, 1'b0, 8'h00, 0, "R11 rx off");
    endtask

    task automatic test_full_time();
        logic s_oe, s_txd, s_en, s_ck;
        logic [7:0] b0, b1;
        int v0;
        b0 = 8'h6D; b1 = 8'h12;
        cfg_tdm = 1'b0; cfg_ext = 1'b0;
        cfg_tx_en = 1'b0; cfg_rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R11", "line oe with tx off", 32'(tx_line_oe), 32'd0);
        cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
        load_byte(8'hB4);
        check("R10", "tx clock oe internal", 32'(tx_clk_oe), 32'd1);
        check("R10", "tx clock out high", 32'(tx_clk_out), 32'd1);
        v0 = vcount;
        for (int k = 0; k < 16; k++) begin
            logic rb;
            logic [7:0] exp_tx;
            rb = (k < 8) ? b0[7-k] : b1[15-k];
            exp_tx = (k < 8) ? 8'hB4 : 8'hFF;
            bit_cycle((k == 3) || (k == 9), rb, s_oe, s_txd, s_en, s_ck);
            check("R9", $sformatf("line oe bit %0d", k), 32'(s_oe), 32'd1);
            check("R9", $sformatf("driver enable bit %0d", k), 32'(s_en), 32'd1);
            check("R9 R8", $sformatf("tx bit %0d", k), 32'(s_txd), 32'(exp_tx[7-(k%8)]));
            check("R10", $sformatf("tx clock out low bit %0d", k), 32'(s_ck), 32'd0);
            if (k == 7) begin
                check("R9", "first byte count", 32'(vcount - v0), 32'd1);
                check("R9", "first byte", 32'(vbyte), 32'(b0));
            end
        end
        check("R9 R6", "second byte count", 32'(vcount - v0), 32'd2);
        check("R9", "second byte", 32'(vbyte), 32'(b1));
    endtask

    task automatic test_ext_clock();
        logic [7:0] b;
        b = 8'h81;
        cfg_tx_en = 1'b0;
        cfg_ext = 1'b1;
        repeat (2) @(negedge clk);
        cfg_tx_en = 1'b1;
        load_byte(b);
        check("R10", "tx clock oe external", 32'(tx_clk_oe), 32'd0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            tx_clk_in = 1'b0;
            repeat (3) @(negedge clk);
            check("R10", $sformatf("ext clock tx bit %0d", k), 32'(tx_line), 32'(b[7-k]));
            @(negedge clk);
            tx_clk_in = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_presync();
        test_slot_basic();
        test_idle_ones();
        test_boundaries();
        test_enables_off();
        test_full_time();
        test_ext_clock();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule